// File: doc/BRIEF.md
# Framed Serial Command Transceiver

This block is a master for a three-wire, full-duplex command link to an external controller. The three wires are a clock output, a data output and a data input. A one-cycle start request launches one exchange, and the block then works through it on its own. It raises both lines briefly, then opens a frame with a start condition. It moves a 32-bit command out of the data output while a 32-bit reply comes in on the data input, and it closes the frame with a stop condition. When the frame is over, a done strobe marks the reply as valid on the status output.

Every line change is paced by a step timer. The step length is a parameter in clock cycles. Each stage of the frame holds its line levels for exactly one step. The data input is asynchronous to the block's clock, so it passes through a synchronizer chain before it is sampled. The two most significant bits of the reported status are not taken from the wire. They are the two page bits of the command that was sent, so the caller can tell which command a reply belongs to.

Top module: `cmd_xchg_master`

## Requirements
- R1: After reset and whenever `busy_o` is low, `sck_o` and `sdo_o` are both 1, and `done_o` is 0 except in the single cycle that ends an exchange.
- R2: The cycle after `start_i` is seen with `busy_o` low, `busy_o` rises and both lines stay high for one step. Then `sdo_o` falls while `sck_o` is still high, and `sck_o` falls exactly one step after `sdo_o` fell.
- R3: The command is sent as exactly WORD_W bits, bit WORD_W-1 first. Each bit is on `sdo_o` before `sck_o` rises, so a receiver that captures on the rising clock edge rebuilds the command exactly.
- R4: Every bit period is three steps long: data is placed with the clock low, then the clock is high for exactly one step, then the clock is low for one step.
- R5: `sdi_i` is sampled once per bit, at the end of the low step that follows the falling clock, after a SYNC_STAGES-flop synchronizer. Each sample is shifted in at status bit 0, so the first bit received ends up in bit WORD_W-1.
- R6: After the last bit, `sck_o` rises while `sdo_o` is 0. Exactly one step later `sdo_o` rises with `sck_o` still high, and this ends the frame.
- R7: When the exchange completes, status bits WORD_W-1 down to WORD_W-PAGE_W hold the same bits of the command that was sent. The lower bits hold the received data.
- R8: In the cycle after a start is accepted, `status_o` reads all zeros.
- R9: A `start_i` pulse that arrives while `busy_o` is high has no effect on the command being sent, and it starts no further exchange.
- R10: `done_o` is high for exactly one cycle, in the cycle where `busy_o` first reads low. `status_o` holds the final reply in that cycle.
- R11: From the edge that accepts a start to the edge that raises `done_o` there are exactly (3*WORD_W+5)*STEP_CYCLES clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin an exchange; acted on only while idle |
| cmd_i | input | WORD_W | Command word, taken in the cycle the start is accepted |
| busy_o | output | 1 | High from the accepted start until the end of the stop condition |
| done_o | output | 1 | One-cycle strobe: the reply on `status_o` is final |
| status_o | output | WORD_W | Received reply, with the page bits taken from the command |
| sck_o | output | 1 | Link clock line |
| sdo_o | output | 1 | Link data line toward the controller |
| sdi_i | input | 1 | Link data line from the controller |

## Verification
The bench builds the block with a step of two cycles, the default 32-bit word, two page bits and a two-flop synchronizer. A two-cycle step is the shortest step under which a reply bit, changed at the rising clock, still gets through the synchronizer before the end of the following low step. This exercises the sampling rule at its tightest point. It also keeps each frame near two hundred cycles, so that dozens of random commands and replies fit in the run. The short step also lets the bench count every high phase, the start and stop gaps, and the overall frame length to the exact cycle.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

    // Stages of one framed exchange, in the order the sequencer visits them.
    typedef enum logic [3:0] {
        PH_IDLE,
        PH_SETUP,     // both lines high for one step
        PH_ST_DATA,   // start: data low, clock high
        PH_ST_CLK,    // start: clock low
        PH_B_SET,     // bit: data placed, clock low
        PH_B_HIGH,    // bit: clock high
        PH_B_LOW,     // bit: clock low again, sample at the end
        PH_SP_CLK,    // stop: clock high, data low
        PH_SP_DATA    // stop: data high
    } phase_e;

endpackage

// File: rtl/xchg_step_timer.sv
module xchg_step_timer #(
    parameter int STEP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = run_i && (st_q.cnt == LAST);
        if (!run_i || tick_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/xchg_sync.sv
module xchg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    generate
        if (STAGES == 0) begin : g_bypass
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst_n;
            assign q_o = d_i;
        end else begin : g_chain
            logic [STAGES-1:0] chain_d, chain_q;
            always_comb begin
                chain_d    = chain_q;
                chain_d[0] = d_i;
                for (int i = 1; i < STAGES; i++) begin
                    chain_d[i] = chain_q[i-1];
                end
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= '1;
                end else begin
                    chain_q <= chain_d;
                end
            end
            assign q_o = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/xchg_shift_unit.sv
module xchg_shift_unit #(
    parameter int WORD_W = 32,
    parameter int PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] cmd_i,
    input  logic              advance_i,
    input  logic              finish_i,
    input  logic              sdi_i,
    output logic              bit_o,
    output logic              bit_next_o,
    output logic [WORD_W-1:0] status_o
);
    typedef struct packed {
        logic [WORD_W-1:0] cmd;
        logic [WORD_W-1:0] status;
        logic [PAGE_W-1:0] page;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cmd    = cmd_i;
            st_d.status = '0;
            st_d.page   = cmd_i[WORD_W-1 -: PAGE_W];
        end else if (advance_i) begin
            st_d.cmd    = {st_q.cmd[WORD_W-2:0], 1'b0};
            st_d.status = {st_q.status[WORD_W-2:0], sdi_i};
        end else if (finish_i) begin
            st_d.status[WORD_W-1 -: PAGE_W] = st_q.page;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_o      = st_q.cmd[WORD_W-1];
    assign bit_next_o = st_q.cmd[WORD_W-2];
    assign status_o   = st_q.status;
endmodule

// File: rtl/xchg_sequencer.sv
module xchg_sequencer
    import xchg_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tick_i,
    input  logic bit_i,
    input  logic bit_next_i,
    output logic busy_o,
    output logic done_o,
    output logic sck_o,
    output logic sdo_o,
    output logic load_o,
    output logic advance_o,
    output logic finish_o
);
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    typedef struct packed {
        phase_e           phase;
        logic [BIT_W-1:0] bitn;
        logic             sck;
        logic             sdo;
        logic             done;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        load_o    = 1'b0;
        advance_o = 1'b0;
        finish_o  = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                st_d.sck = 1'b1;
                st_d.sdo = 1'b1;
                if (start_i) begin
                    st_d.phase = PH_SETUP;
                    load_o     = 1'b1;
                end
            end
            PH_SETUP: if (tick_i) begin
                st_d.phase = PH_ST_DATA;
                st_d.sdo   = 1'b0;
            end
            PH_ST_DATA: if (tick_i) begin
                st_d.phase = PH_ST_CLK;
                st_d.sck   = 1'b0;
            end
            PH_ST_CLK: if (tick_i) begin
                st_d.phase = PH_B_SET;
                st_d.bitn  = '0;
                st_d.sdo   = bit_i;
            end
            PH_B_SET: if (tick_i) begin
                st_d.phase = PH_B_HIGH;
                st_d.sck   = 1'b1;
            end
            PH_B_HIGH: if (tick_i) begin
                st_d.phase = PH_B_LOW;
                st_d.sck   = 1'b0;
            end
            PH_B_LOW: if (tick_i) begin
                advance_o = 1'b1;
                if (st_q.bitn == LAST_BIT) begin
                    st_d.phase = PH_SP_CLK;
                    st_d.sck   = 1'b1;
                    st_d.sdo   = 1'b0;
                end else begin
                    st_d.phase = PH_B_SET;
                    st_d.bitn  = st_q.bitn + 1'b1;
                    st_d.sdo   = bit_next_i;
                end
            end
            PH_SP_CLK: if (tick_i) begin
                st_d.phase = PH_SP_DATA;
                st_d.sdo   = 1'b1;
            end
            PH_SP_DATA: if (tick_i) begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
                finish_o   = 1'b1;
            end
            default: begin
                st_d.phase = PH_IDLE;
                st_d.sck   = 1'b1;
                st_d.sdo   = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.bitn  <= '0;
            st_q.sck   <= 1'b1;
            st_q.sdo   <= 1'b1;
            st_q.done  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = (st_q.phase != PH_IDLE);
    assign done_o = st_q.done;
    assign sck_o  = st_q.sck;
    assign sdo_o  = st_q.sdo;
endmodule

// File: rtl/cmd_xchg_master.sv
module cmd_xchg_master #(
    parameter int WORD_W      = 32,
    parameter int PAGE_W      = 2,
    parameter int STEP_CYCLES = 50,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] cmd_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] status_o,
    output logic              sck_o,
    output logic              sdo_o,
    input  logic              sdi_i
);
    logic tick, busy, load, advance, finish;
    logic cur_bit, next_bit, sdi_sync;

    xchg_step_timer #(.STEP_CYCLES(STEP_CYCLES)) tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy),
        .tick_o (tick)
    );

    xchg_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sdi_i),
        .q_o   (sdi_sync)
    );

    xchg_shift_unit #(.WORD_W(WORD_W), .PAGE_W(PAGE_W)) shf_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .cmd_i      (cmd_i),
        .advance_i  (advance),
        .finish_i   (finish),
        .sdi_i      (sdi_sync),
        .bit_o      (cur_bit),
        .bit_next_o (next_bit),
        .status_o   (status_o)
    );

    xchg_sequencer #(.WORD_W(WORD_W)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .tick_i     (tick),
        .bit_i      (cur_bit),
        .bit_next_i (next_bit),
        .busy_o     (busy),
        .done_o     (done_o),
        .sck_o      (sck_o),
        .sdo_o      (sdo_o),
        .load_o     (load),
        .advance_o  (advance),
        .finish_o   (finish)
    );

    assign busy_o = busy;
endmodule

// File: rtl/xchg_checker.sv
module xchg_checker #(
    parameter int WORD_W = 32,
    parameter int PAGE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [WORD_W-1:0] cmd_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [WORD_W-1:0] status_o,
    input logic              sck_o,
    input logic              sdo_o
);
    logic [PAGE_W-1:0] page_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_seen_q <= '0;
        end else if (start_i && !busy_o) begin
            page_seen_q <= cmd_i[WORD_W-1 -: PAGE_W];
        end
    end

    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (sck_o && sdo_o));

    assert_status_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (status_o == '0));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    assert_page_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (status_o[WORD_W-1 -: PAGE_W] == page_seen_q));
endmodule

bind cmd_xchg_master xchg_checker #(.WORD_W(WORD_W), .PAGE_W(PAGE_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .cmd_i    (cmd_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .status_o (status_o),
    .sck_o    (sck_o),
    .sdo_o    (sdo_o)
);

// File: tb/cmd_xchg_master_tb_top.sv
module cmd_xchg_master_tb_top;
    localparam int W      = 32;
    localparam int P      = 2;
    localparam int S      = 2;
    localparam int FRAME  = (3 * W + 5) * S;
    localparam int LIMIT  = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] cmd = '0;
    logic         busy, done, sck, sdo;
    logic         sdi = 1'b1;
    logic [W-1:0] status;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cmd_xchg_master #(.WORD_W(W), .PAGE_W(P), .STEP_CYCLES(S), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_i(cmd),
        .busy_o(busy), .done_o(done), .status_o(status),
        .sck_o(sck), .sdo_o(sdo), .sdi_i(sdi)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_status(input logic [W-1:0] c, input logic [W-1:0] r);
        exp_status = {c[W-1 -: P], r[W-P-1:0]};
    endfunction

    // Controller model and line monitor, all at the falling clock edge.
    logic [W-1:0] reply_w = '0;
    logic [W-1:0] cap = '0;
    int  k = 0, cyc = 0, hi = 0, frames = 0, done_cnt = 0;
    bit  in_frame = 0, wait_st = 0, wait_sp = 0;
    logic p_sck = 1'b1, p_sdo = 1'b1, p_done = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (done) begin
                done_cnt++;
                if (p_done) check(0, "R10 done longer than one cycle", 1, 0);
            end
            if (!in_frame && p_sck && sck && p_sdo && !sdo) begin
                in_frame = 1; wait_st = 1; k = 0; cyc = 0; cap = '0;
            end
            if (p_sck && !sck) begin
                if (wait_st) begin
                    check(cyc == S && !sdo, "R2 start clock gap", W'(cyc), W'(S));
                    wait_st = 0;
                end else if (in_frame) begin
                    check(hi == S, "R4 clock high length", W'(hi), W'(S));
                end
            end
            if (!p_sck && sck && in_frame) begin
                hi = 1;
                if (k < W) begin
                    cap = {cap[W-2:0], sdo};
                    sdi = reply_w[W-1-k];
                    k++;
                end else begin
                    check(!sdo, "R6 data low at stop clock rise", W'(sdo), 0);
                    wait_sp = 1; cyc = 0;
                end
            end else if (sck) begin
                hi++;
            end
            if (wait_sp && sck && !p_sdo && sdo) begin
                check(cyc == S, "R6 stop data gap", W'(cyc), W'(S));
                wait_sp = 0; in_frame = 0; frames++;
            end
            p_sck = sck; p_sdo = sdo; p_done = done;
        end
    end

    task automatic xchg(input logic [W-1:0] c, input logic [W-1:0] r, input bit inject);
        int n;
        int f0, d0;
        @(negedge clk);
        reply_w = r; f0 = frames; d0 = done_cnt;
        start = 1'b1; cmd = c;
        @(negedge clk);
        start = 1'b0; cmd = ~c;
        n = 1;
        check(status == '0, "R8 status cleared", status, '0);
        check(busy, "R2 busy after accept", W'(busy), 1);
        while (!done && n < 4 * FRAME) begin
            if (inject && n == 10) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            n++;
        end
        check(n == FRAME + 1, "R11 frame length", W'(n), W'(FRAME + 1));
        check(status == exp_status(c, r), "R5 R7 status", status, exp_status(c, r));
        check(cap == c, "R3 command bits", cap, c);
        check(!busy, "R10 busy low with done", W'(busy), 0);
        repeat (2 * S + 4) @(negedge clk);
        check(!busy && done_cnt == d0 + 1 && frames == f0 + 1, "R9 single exchange",
              W'(done_cnt - d0), 1);
        check(sck && sdo && !done, "R1 idle lines", {sck, sdo, done}, 3'b110);
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", LIMIT, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        check(sck && sdo && !busy && !done, "R1 reset state", {sck, sdo, busy, done}, 4'b1100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(sck && sdo && !busy && status == '0, "R1 idle after reset", status, '0);
        xchg('0, '1, 0);
        xchg('1, '0, 0);
        xchg(32'hA5C3_0F81, 32'h5555_AAAA, 0);
        xchg(32'h4000_0001, 32'hC000_0003, 1);
        xchg(32'h8123_4567, 32'h3FFF_FFFE, 1);
        for (int t = 0; t < 30; t++) begin
            xchg($urandom, $urandom, ($urandom % 4) == 0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule